// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbitration Scanner

This block chooses the mailbox a CAN controller sends next. Once launched, it walks the mailbox set one entry per clock. It presents each index on a read port and takes back that mailbox's code and priority in the same cycle. A running best candidate is kept as the walk proceeds. When the walk ends normally, the block publishes the winning index with a valid flag.

A scan can be cut short by bus events, by the end of the available time, by a restart, or by edits to mailboxes. A sticky pending flag records that the last result may be stale. The protocol engine then relaunches the scan at its next start strobe. An optional lowest-buffer mode ends the walk at the first mailbox that is armed for transmission.

Top module: `can_tx_arb_scanner`

## Requirements
- R1: Mailbox codes are 2 bits: 2'b00 empty, 2'b01 armed for transmit, 2'b10 and 2'b11 receive. With lowest-buffer mode off, a completed scan reports the armed mailbox with the smallest priority value, and equal priorities go to the lower index. `win_valid_o` rises only on the clock edge that ends a scan normally.
- R2: A launched scan holds `busy_o` high for exactly N_MB cycles. `rd_idx_o` shows 0, 1, …, N_MB-1 in those cycles, one step per clock.
- R3: With lowest-buffer mode on, the scan ends in the cycle that examines the first armed mailbox and reports that mailbox, even if a later one has a smaller priority value.
- R4: A completed scan that found no armed mailbox leaves `win_valid_o` low.
- R5: While scanning, any of these abandons the scan on the next edge with `win_valid_o` low and `pending_o` unchanged: winner deactivation/abort, a bus error/overload flag, or a freeze or low-power request while `idle_i` is high. A freeze request without `idle_i` has no effect. Abandonment has priority over R6, R8 and R11.
- R6: `deadline_i` during a scan stops it and sets `pending_o`.
- R7: During a scan, a control/status write to an index at or below `rd_idx_o` sets `pending_o`, unless it hits the current winner. A write above `rd_idx_o` sets nothing, and the scan still examines that mailbox's new contents.
- R8: During a scan, a control/status write to the current winner restarts the scan at index 0 on the next edge and does not set `pending_o`.
- R9: A control/status write while idle sets `pending_o`. A receive-to-transmit code conversion sets `pending_o`, and so does bus-off entry, at any time.
- R10: While idle, `start_i` launches a scan only if `pending_o` is set, and the launch clears `pending_o`. A set event in the same cycle wins over the clear. `freeze_exit_i` launches a scan whether or not `pending_o` is set. Launching clears `win_valid_o`.
- R11: `resync_i` during a scan restarts it at index 0.
- R12: After reset, `busy_o`, `pending_o`, `win_valid_o` and `win_idx_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lowest_buf_en_i | input | 1 | Stop at first armed mailbox |
| start_i | input | 1 | Scan start strobe from protocol engine |
| deadline_i | input | 1 | Time for arbitration has run out |
| cs_wr_i | input | 1 | Control/status write event |
| cs_wr_idx_i | input | IDX_W | Mailbox index of the write |
| win_deact_i | input | 1 | Current winner deactivated or aborted |
| bus_err_i | input | 1 | Error or overload flag on the bus |
| idle_i | input | 1 | Protocol engine is in its idle state |
| freeze_req_i | input | 1 | Freeze mode request |
| lowpwr_req_i | input | 1 | Low-power mode request |
| freeze_exit_i | input | 1 | Leaving freeze mode |
| resync_i | input | 1 | Resynchronization while waiting for bus idle |
| busoff_i | input | 1 | Entering bus-off |
| rx2tx_i | input | 1 | Receive match turned an Rx code into a Tx code |
| rd_idx_o | output | IDX_W | Mailbox index being examined |
| mb_code_i | input | 2 | Code of mailbox `rd_idx_o` |
| mb_prio_i | input | PRIO_W | Priority value of mailbox `rd_idx_o` |
| busy_o | output | 1 | Scan in progress |
| pending_o | output | 1 | A new scan is needed |
| win_valid_o | output | 1 | Winner result is valid |
| win_idx_o | output | IDX_W | Winning mailbox index |

## Verification
The assertions assume that `mb_code_i` and `mb_prio_i` settle combinationally from `rd_idx_o` within the cycle. They also assume the event strobes are single-cycle pulses that hold steady between clock edges. The stimulus models the mailbox store as an array indexed by `rd_idx_o`, and it drives every strobe for one full cycle from the falling edge. Mailbox contents change only together with a matching control/status write, or while no scan is running. Because of this, the expected winner computed over the array matches what the scan could legally observe.

// File: rtl/can_arb_pkg.sv
`timescale 1ns/1ps
// Shared types for the transmit arbitration scanner.
// Assumes: mailbox codes are two bits wide.
package can_arb_pkg;

    // Mailbox code as seen on the read port.
    typedef enum logic [1:0] {
        MB_EMPTY   = 2'b00,
        MB_TX_ARM  = 2'b01,
        MB_RX      = 2'b10,
        MB_RX_FULL = 2'b11
    } mb_code_e;

    // Per-cycle command from the event controller to the scan core.
    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_LAUNCH  = 3'd1,
        CMD_RESTART = 3'd2,
        CMD_ABORT   = 3'd3,
        CMD_LATE    = 3'd4
    } scan_cmd_e;

endpackage

// File: rtl/arb_cmp.sv
`timescale 1ns/1ps
// Candidate comparator: decides whether the mailbox under the pointer
// displaces the running best. Assumes mailboxes arrive in ascending index
// order, so a strict compare hands ties to the lower index.
module arb_cmp
    import can_arb_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic [1:0]        cand_code_i,
    input  logic [PRIO_W-1:0] cand_prio_i,
    input  logic              best_valid_i,
    input  logic [PRIO_W-1:0] best_prio_i,
    output logic              cand_tx_o,
    output logic              take_o
);

    // Armed test and strict priority comparison.
    always_comb begin
        cand_tx_o = (mb_code_e'(cand_code_i) == MB_TX_ARM);
        take_o    = cand_tx_o && (!best_valid_i || (cand_prio_i < best_prio_i));
    end

endmodule

// File: rtl/arb_scan_core.sv
`timescale 1ns/1ps
// Scan core: owns the pointer, the busy flag and the running best.
// Acts on a one-hot-in-time command from the event controller and
// reports a combinational finish with the final winner.
// Assumes: cand_* reflect mailbox ptr_o in the same cycle.
module arb_scan_core
    import can_arb_pkg::*;
#(
    parameter int N_MB   = 16,
    parameter int PRIO_W = 8,
    localparam int IDX_W = (N_MB > 1) ? $clog2(N_MB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  scan_cmd_e         cmd_i,
    input  logic              lowest_buf_en_i,
    input  logic [1:0]        cand_code_i,
    input  logic [PRIO_W-1:0] cand_prio_i,
    output logic              busy_o,
    output logic [IDX_W-1:0]  ptr_o,
    output logic              best_valid_o,
    output logic [IDX_W-1:0]  best_idx_o,
    output logic              fin_o,
    output logic              fin_valid_o,
    output logic [IDX_W-1:0]  fin_idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_MB - 1);
    localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);

    logic              busy_q;
    logic [IDX_W-1:0]  ptr_q;
    logic              best_valid_q;
    logic [IDX_W-1:0]  best_idx_q;
    logic [PRIO_W-1:0] best_prio_q;
    logic              take;
    logic              cand_tx;
    logic              stepping;

    arb_cmp #(.PRIO_W(PRIO_W)) i_cmp (
        .cand_code_i  (cand_code_i),
        .cand_prio_i  (cand_prio_i),
        .best_valid_i (best_valid_q),
        .best_prio_i  (best_prio_q),
        .cand_tx_o    (cand_tx),
        .take_o       (take)
    );

    // Finish detection and the winner that a finish would publish.
    always_comb begin
        stepping    = busy_q && (cmd_i == CMD_NONE);
        fin_o       = stepping && ((ptr_q == LAST_IDX) || (lowest_buf_en_i && cand_tx));
        fin_valid_o = take || best_valid_q;
        fin_idx_o   = take ? ptr_q : (best_valid_q ? best_idx_q : '0);
    end

    // Pointer, busy flag and running best.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q       <= 1'b0;
            ptr_q        <= '0;
            best_valid_q <= 1'b0;
            best_idx_q   <= '0;
            best_prio_q  <= '0;
        end else begin
            unique case (cmd_i)
                CMD_LAUNCH, CMD_RESTART: begin
                    busy_q       <= 1'b1;
                    ptr_q        <= '0;
                    best_valid_q <= 1'b0;
                end
                CMD_ABORT, CMD_LATE: begin
                    busy_q       <= 1'b0;
                    ptr_q        <= '0;
                    best_valid_q <= 1'b0;
                end
                default: begin
                    if (stepping) begin
                        if (fin_o) begin
                            busy_q       <= 1'b0;
                            ptr_q        <= '0;
                            best_valid_q <= 1'b0;
                        end else begin
                            ptr_q <= ptr_q + ONE_IDX;
                            if (take) begin
                                best_valid_q <= 1'b1;
                                best_idx_q   <= ptr_q;
                                best_prio_q  <= cand_prio_i;
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign busy_o       = busy_q;
    assign ptr_o        = ptr_q;
    assign best_valid_o = best_valid_q;
    assign best_idx_o   = best_idx_q;

    // The pointer never leaves the mailbox range during a scan.
    assert_ptr_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (ptr_q <= LAST_IDX));

    // A restart command lands the scan back at index zero.
    assert_restart_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_RESTART) |=> (busy_q && (ptr_q == '0)));

    // In lowest-buffer mode the first armed mailbox ends the walk.
    assert_lowbuf_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && lowest_buf_en_i && cand_tx) |=> !busy_q);

endmodule

// File: rtl/arb_event_ctrl.sv
`timescale 1ns/1ps
// Event controller: ranks the protocol events into one command per cycle
// and keeps the sticky pending flag.
// Order while scanning: abandon, then deadline, then restart.
// Assumes: every strobe is a single-cycle pulse.
module arb_event_ctrl
    import can_arb_pkg::*;
#(
    parameter int N_MB   = 16,
    localparam int IDX_W = (N_MB > 1) ? $clog2(N_MB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic [IDX_W-1:0] ptr_i,
    input  logic             best_valid_i,
    input  logic [IDX_W-1:0] best_idx_i,
    input  logic             start_i,
    input  logic             deadline_i,
    input  logic             cs_wr_i,
    input  logic [IDX_W-1:0] cs_wr_idx_i,
    input  logic             win_deact_i,
    input  logic             bus_err_i,
    input  logic             idle_i,
    input  logic             freeze_req_i,
    input  logic             lowpwr_req_i,
    input  logic             freeze_exit_i,
    input  logic             resync_i,
    input  logic             busoff_i,
    input  logic             rx2tx_i,
    output scan_cmd_e        cmd_o,
    output logic             pending_o
);

    logic pending_q;
    logic abandon;
    logic hit_winner;
    logic pend_set;
    logic cs_low_hit;

    // Rank this cycle's events into a single command.
    always_comb begin
        abandon    = busy_i && (win_deact_i || bus_err_i ||
                                ((freeze_req_i || lowpwr_req_i) && idle_i));
        hit_winner = cs_wr_i && best_valid_i && (cs_wr_idx_i == best_idx_i);
        if (!busy_i) begin
            cmd_o = (freeze_exit_i || (start_i && pending_q)) ? CMD_LAUNCH : CMD_NONE;
        end else if (abandon) begin
            cmd_o = CMD_ABORT;
        end else if (deadline_i) begin
            cmd_o = CMD_LATE;
        end else if (resync_i || hit_winner) begin
            cmd_o = CMD_RESTART;
        end else begin
            cmd_o = CMD_NONE;
        end
    end

    // Collect every reason that makes the current result stale.
    always_comb begin
        cs_low_hit = busy_i && cs_wr_i && (cs_wr_idx_i <= ptr_i) && !hit_winner;
        pend_set   = (cmd_o == CMD_LATE) || (cs_wr_i && !busy_i) || cs_low_hit ||
                     rx2tx_i || busoff_i;
    end

    // Sticky pending flag: set wins over the clear on launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (pend_set) begin
            pending_q <= 1'b1;
        end else if (cmd_o == CMD_LAUNCH) begin
            pending_q <= 1'b0;
        end
    end

    assign pending_o = pending_q;

    // A deadline stop always leaves pending set.
    assert_late_sets_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && deadline_i && !abandon) |=> pending_q);

    // Code conversion and bus-off entry always leave pending set.
    assert_rx2tx_busoff_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx2tx_i || busoff_i) |=> pending_q);

    // A start with nothing pending and no freeze exit does not launch.
    assert_start_needs_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && start_i && !pending_q && !freeze_exit_i) |=> !busy_i);

    // A write to the current winner never marks pending by itself.
    assert_winner_write_no_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && hit_winner && !abandon && !deadline_i && !rx2tx_i && !busoff_i &&
         !pending_q) |=> !pending_q);

endmodule

// File: rtl/can_tx_arb_scanner.sv
`timescale 1ns/1ps
// Transmit mailbox arbitration scanner, top level.
// Connects the event controller and the scan core, and registers the
// published winner. Assumes the mailbox store answers rd_idx_o
// combinationally with mb_code_i / mb_prio_i.
module can_tx_arb_scanner
    import can_arb_pkg::*;
#(
    parameter int N_MB   = 16,
    parameter int PRIO_W = 8,
    localparam int IDX_W = (N_MB > 1) ? $clog2(N_MB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lowest_buf_en_i,
    input  logic              start_i,
    input  logic              deadline_i,
    input  logic              cs_wr_i,
    input  logic [IDX_W-1:0]  cs_wr_idx_i,
    input  logic              win_deact_i,
    input  logic              bus_err_i,
    input  logic              idle_i,
    input  logic              freeze_req_i,
    input  logic              lowpwr_req_i,
    input  logic              freeze_exit_i,
    input  logic              resync_i,
    input  logic              busoff_i,
    input  logic              rx2tx_i,
    output logic [IDX_W-1:0]  rd_idx_o,
    input  logic [1:0]        mb_code_i,
    input  logic [PRIO_W-1:0] mb_prio_i,
    output logic              busy_o,
    output logic              pending_o,
    output logic              win_valid_o,
    output logic [IDX_W-1:0]  win_idx_o
);

    scan_cmd_e        cmd;
    logic             busy;
    logic [IDX_W-1:0] ptr;
    logic             best_valid;
    logic [IDX_W-1:0] best_idx;
    logic             fin;
    logic             fin_valid;
    logic [IDX_W-1:0] fin_idx;
    logic             win_valid_q;
    logic [IDX_W-1:0] win_idx_q;

    arb_event_ctrl #(.N_MB(N_MB)) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .busy_i        (busy),
        .ptr_i         (ptr),
        .best_valid_i  (best_valid),
        .best_idx_i    (best_idx),
        .start_i       (start_i),
        .deadline_i    (deadline_i),
        .cs_wr_i       (cs_wr_i),
        .cs_wr_idx_i   (cs_wr_idx_i),
        .win_deact_i   (win_deact_i),
        .bus_err_i     (bus_err_i),
        .idle_i        (idle_i),
        .freeze_req_i  (freeze_req_i),
        .lowpwr_req_i  (lowpwr_req_i),
        .freeze_exit_i (freeze_exit_i),
        .resync_i      (resync_i),
        .busoff_i      (busoff_i),
        .rx2tx_i       (rx2tx_i),
        .cmd_o         (cmd),
        .pending_o     (pending_o)
    );

    arb_scan_core #(.N_MB(N_MB), .PRIO_W(PRIO_W)) i_core (
        .clk             (clk),
        .rst_n           (rst_n),
        .cmd_i           (cmd),
        .lowest_buf_en_i (lowest_buf_en_i),
        .cand_code_i     (mb_code_i),
        .cand_prio_i     (mb_prio_i),
        .busy_o          (busy),
        .ptr_o           (ptr),
        .best_valid_o    (best_valid),
        .best_idx_o      (best_idx),
        .fin_o           (fin),
        .fin_valid_o     (fin_valid),
        .fin_idx_o       (fin_idx)
    );

    // Published winner: cleared at launch, loaded on normal finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid_q <= 1'b0;
            win_idx_q   <= '0;
        end else if (cmd == CMD_LAUNCH) begin
            win_valid_q <= 1'b0;
        end else if (fin) begin
            win_valid_q <= fin_valid;
            win_idx_q   <= fin_idx;
        end
    end

    assign rd_idx_o    = ptr;
    assign busy_o      = busy;
    assign win_valid_o = win_valid_q;
    assign win_idx_o   = win_idx_q;

    // A valid winner appears only as a scan ends.
    assert_valid_at_scan_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_valid_o) |-> ($past(busy) && !busy));

    // An abandoned scan leaves nothing published.
    assert_abort_no_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ABORT) |=> (!busy && !win_valid_o));

    // While a scan runs the previous result is withdrawn.
    assert_no_stale_winner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !win_valid_o);

endmodule

// File: tb/test_can_tx_arb_scanner.sv
`timescale 1ns/1ps
module test_can_tx_arb_scanner;

    localparam int N  = 16;
    localparam int PW = 8;
    localparam int IW = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          lb_en = 0, start = 0, deadline = 0, cs_wr = 0;
    logic [IW-1:0] cs_idx = '0;
    logic          deact = 0, berr = 0, idle = 0, frz = 0, lpw = 0;
    logic          frz_exit = 0, resync = 0, boff = 0, rx2tx = 0;
    logic [IW-1:0] rd_idx;
    logic [1:0]    mb_code;
    logic [PW-1:0] mb_prio;
    logic          busy, pending, win_valid;
    logic [IW-1:0] win_idx;

    logic [1:0]    tb_code [N];
    logic [PW-1:0] tb_prio [N];

    assign mb_code = tb_code[rd_idx];
    assign mb_prio = tb_prio[rd_idx];

    can_tx_arb_scanner #(.N_MB(N), .PRIO_W(PW)) i_can_tx_arb_scanner (
        .clk(clk), .rst_n(rst_n), .lowest_buf_en_i(lb_en), .start_i(start),
        .deadline_i(deadline), .cs_wr_i(cs_wr), .cs_wr_idx_i(cs_idx),
        .win_deact_i(deact), .bus_err_i(berr), .idle_i(idle),
        .freeze_req_i(frz), .lowpwr_req_i(lpw), .freeze_exit_i(frz_exit),
        .resync_i(resync), .busoff_i(boff), .rx2tx_i(rx2tx),
        .rd_idx_o(rd_idx), .mb_code_i(mb_code), .mb_prio_i(mb_prio),
        .busy_o(busy), .pending_o(pending), .win_valid_o(win_valid),
        .win_idx_o(win_idx)
    );

    typedef struct packed {
        logic          v;
        logic [IW-1:0] idx;
        logic          pend;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];
    int    n_checks = 0;
    int    n_err = 0;
    bit    reported = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    endtask

    // Expected winner over the bench mailbox array (R1, R3, R4).
    function automatic exp_t ref_win(input bit lb, input bit pend);
        exp_t r;
        int   best;
        best = -1;
        for (int i = 0; i < N; i++) begin
            if (tb_code[i] == 2'b01) begin
                if (best < 0 || tb_prio[i] < tb_prio[best]) best = i;
                if (lb) break;
            end
        end
        r.v    = (best >= 0);
        r.idx  = (best >= 0) ? IW'(best) : '0;
        r.pend = pend;
        return r;
    endfunction

    task automatic push(input exp_t e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic push_raw(input bit v, input int idx, input bit pend, input string tag);
        exp_t e;
        e.v = v; e.idx = IW'(idx); e.pend = pend;
        push(e, tag);
    endtask

    // Monitor: pops one expectation at every scan end.
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        exp_t  e;
        string t;
        if (rst_n && prev_busy && !busy) begin
            if (exp_q.size() == 0) begin
                chk(0, "R1", "unexpected scan end", 1, 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(win_valid == e.v, t, "win_valid", int'(win_valid), int'(e.v));
                if (e.v) chk(win_idx == e.idx, t, "win_idx", int'(win_idx), int'(e.idx));
                chk(pending == e.pend, t, "pending", int'(pending), int'(e.pend));
            end
        end
        prev_busy = busy;
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R2", "watchdog expired", 0, 1);
        report();
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic launch_freeze();
        frz_exit = 1; tick(); frz_exit = 0;
    endtask

    task automatic launch_start();
        start = 1; tick(); start = 0;
    endtask

    task automatic wait_idle();
        while (busy) tick();
    endtask

    task automatic clear_mbs();
        for (int i = 0; i < N; i++) begin
            tb_code[i] = 2'b00;
            tb_prio[i] = 8'd255;
        end
    endtask

    initial begin
        int mis;
        int cnt;
        clear_mbs();
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R12 reset state
        chk(!busy && !pending && !win_valid && win_idx == 0, "R12", "reset outputs",
            int'({busy, pending, win_valid}), 0);

        // R1 / R2: mixed codes, full walk, last index wins
        for (int i = 0; i < N; i++) begin
            tb_code[i] = (i % 3 == 0) ? 2'b01 : ((i % 3 == 1) ? 2'b10 : 2'b00);
            tb_prio[i] = PW'(200 - i * 7);
        end
        push(ref_win(0, 0), "R1");
        launch_freeze();
        mis = 0;
        for (int k = 0; k < N; k++) begin
            if (rd_idx != IW'(k) || !busy) mis++;
            tick();
        end
        chk(mis == 0, "R2", "index sequence mismatches", mis, 0);
        chk(!busy, "R2", "busy after N cycles", int'(busy), 0);

        // R1 ties go to lower index
        clear_mbs();
        tb_code[4] = 2'b01;  tb_prio[4] = 8'd10;
        tb_code[7] = 2'b01;  tb_prio[7] = 8'd3;
        tb_code[11] = 2'b01; tb_prio[11] = 8'd3;
        tb_code[2] = 2'b11;  tb_prio[2] = 8'd0;
        push_raw(1, 7, 0, "R1");
        launch_freeze(); wait_idle();

        // R4 no armed mailbox
        clear_mbs();
        tb_code[0] = 2'b10; tb_prio[0] = 8'd0;
        tb_code[5] = 2'b11; tb_prio[5] = 8'd1;
        push_raw(0, 0, 0, "R4");
        launch_freeze(); wait_idle();

        // R3 lowest-buffer mode stops early
        clear_mbs();
        tb_code[3] = 2'b01; tb_prio[3] = 8'd200;
        tb_code[9] = 2'b01; tb_prio[9] = 8'd1;
        lb_en = 1;
        push_raw(1, 3, 0, "R3");
        launch_freeze();
        cnt = 0;
        while (busy) begin tick(); cnt++; end
        chk(cnt == 4, "R3", "cycles to stop", cnt, 4);
        lb_en = 0;
        push_raw(1, 9, 0, "R1");
        launch_freeze(); wait_idle();

        // R5 abandon cases
        push_raw(0, 0, 0, "R5");
        launch_freeze(); repeat (5) tick();
        berr = 1; tick(); berr = 0;
        chk(!busy, "R5", "busy after bus error", int'(busy), 0);
        push_raw(0, 0, 0, "R5");
        launch_freeze(); repeat (5) tick();
        deact = 1; tick(); deact = 0;
        chk(!busy, "R5", "busy after deactivation", int'(busy), 0);
        push_raw(0, 0, 0, "R5");
        launch_freeze(); repeat (5) tick();
        idle = 1; frz = 1; tick(); frz = 0; idle = 0;
        push_raw(0, 0, 0, "R5");
        launch_freeze(); repeat (5) tick();
        idle = 1; lpw = 1; tick(); lpw = 0; idle = 0;
        push_raw(1, 9, 0, "R5");
        launch_freeze(); repeat (5) tick();
        frz = 1; tick(); frz = 0;
        chk(busy, "R5", "freeze without idle keeps scanning", int'(busy), 1);
        wait_idle();

        // R6 deadline, then R10 launch from pending
        push_raw(0, 0, 1, "R6");
        launch_freeze(); repeat (5) tick();
        deadline = 1; tick(); deadline = 0;
        chk(pending, "R6", "pending after deadline", int'(pending), 1);
        push_raw(1, 9, 0, "R10");
        launch_start();
        chk(busy && !pending, "R10", "launch clears pending",
            int'({busy, pending}), 2);
        wait_idle();

        // R10 start without pending is ignored
        launch_start();
        chk(!busy, "R10", "start without pending", int'(busy), 0);
        tick();
        chk(!busy && !win_valid == 0, "R10", "result kept", int'(win_valid), 1);

        // R9 pending sources
        cs_idx = 4'd5; cs_wr = 1; tick(); cs_wr = 0;
        chk(pending, "R9", "idle write sets pending", int'(pending), 1);
        push_raw(1, 9, 0, "R9");
        launch_start(); wait_idle();
        rx2tx = 1; tick(); rx2tx = 0;
        chk(pending, "R9", "rx2tx sets pending", int'(pending), 1);
        push_raw(1, 9, 0, "R9");
        launch_start(); wait_idle();
        boff = 1; tick(); boff = 0;
        chk(pending, "R9", "bus-off sets pending", int'(pending), 1);
        // R10 set wins over clear in the launch cycle
        push_raw(1, 9, 1, "R10");
        start = 1; rx2tx = 1; tick(); start = 0; rx2tx = 0;
        chk(busy && pending, "R10", "set beats clear", int'({busy, pending}), 3);
        wait_idle();
        push_raw(1, 9, 0, "R10");
        launch_freeze(); wait_idle();

        // R7 write below pointer sets pending
        launch_freeze(); repeat (5) tick();
        cs_idx = 4'd2; cs_wr = 1; tick(); cs_wr = 0;
        push_raw(1, 9, 1, "R7");
        wait_idle();
        // R7 write above pointer: scanned as normal, no pending
        launch_start(); repeat (3) tick();
        tb_code[12] = 2'b01; tb_prio[12] = 8'd0;
        cs_idx = 4'd12; cs_wr = 1; tick(); cs_wr = 0;
        push_raw(1, 12, 0, "R7");
        wait_idle();
        tb_code[12] = 2'b00; tb_prio[12] = 8'd255;

        // R8 write to current winner restarts
        tb_code[1] = 2'b01; tb_prio[1] = 8'd5;
        tb_prio[9] = 8'd50;
        launch_freeze(); repeat (6) tick();
        tb_code[1] = 2'b00;
        cs_idx = 4'd1; cs_wr = 1; tick(); cs_wr = 0;
        chk(busy && rd_idx == 0, "R8", "restart index", int'(rd_idx), 0);
        chk(!pending, "R8", "no pending on winner write", int'(pending), 0);
        push_raw(1, 9, 0, "R8");
        wait_idle();

        // R11 resync restarts and runs a full walk
        push_raw(1, 9, 0, "R11");
        launch_freeze(); repeat (4) tick();
        resync = 1; tick(); resync = 0;
        chk(busy && rd_idx == 0, "R11", "restart index", int'(rd_idx), 0);
        cnt = 0;
        while (busy) begin tick(); cnt++; end
        chk(cnt == N, "R11", "cycles after restart", cnt, N);

        tick();
        chk(exp_q.size() == 0, "R1", "scoreboard left over", exp_q.size(), 0);
        report();
    end

endmodule